// File: doc/BRIEF.md
# UART Baud and Character Timer

This block sits beside a serial receiver and produces the bit-rate tick and a receive timeout. It divides the system clock in two stages. An optional fixed prescale of 8 comes first. A programmable clock divisor follows, and then a per-bit divisor plus one. The result is a single-cycle `baud_tick` at the bit rate.

The block also decodes the line-format field of a mode word into the number of data bits, the parity setting and the number of stop bits. From these it forms the frame length in bits.

A receiver pulses `rx_char` each time it accepts a character. The block counts four character times in baud ticks after that pulse, where one character time is the frame length in bits. When the count ends it emits a one-cycle `timeout` pulse. A later character restarts the count before it ends. The clock divisor is held in an internal register loaded through `div_wr`, and it comes out of reset at 15.

Top module: `uart_char_timer`

## Requirements
- R1: After reset, `baud_tick` and `timeout` are low and the clock divisor holds 15. With mode 0 and per-bit divisor 0, ticks therefore come every 15 clocks.
- R2: With mode bit 0 clear, consecutive `baud_tick` pulses are D*(B+1) clocks apart. D is the loaded clock divisor and B is `bit_div`.
- R3: With mode bit 0 set, consecutive `baud_tick` pulses are 8*D*(B+1) clocks apart.
- R4: A clock divisor of 0 stops `baud_tick` entirely.
- R5: Mode bits 2:1 set `data_bits`. Code 3 gives 6, code 2 gives 7, and codes 0 and 1 give 8.
- R6: Mode bits 5:3 set the parity. Code 0 gives `parity_en`=1 with `parity_odd`=0 (even). Code 1 gives `parity_en`=1 with `parity_odd`=1 (odd). Every other code gives `parity_en`=0.
- R7: Mode bits 7:6 set `stop_bits`. Code 3 gives 1, and any other code gives 2.
- R8: `frame_bits` equals 1 + `data_bits` + `parity_en` + `stop_bits`.
- R9: After an `rx_char` pulse, `timeout` is high for exactly one clock. That clock follows the 4*`frame_bits`-th `baud_tick` counted after the pulse.
- R10: An `rx_char` pulse that arrives before the timeout restarts the count from zero. The cycle after any `rx_char` never shows `timeout`.
- R11: Once a timeout has fired, no further timeout occurs until another `rx_char`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 8 | Prescale select (bit 0) and line-format codes |
| div_wr | input | 1 | Load strobe for the clock divisor |
| div_in | input | DIV_W | New clock divisor value |
| bit_div | input | BDIV_W | Per-bit divisor; the bit time is this value plus one |
| rx_char | input | 1 | One-cycle pulse per accepted received character |
| baud_tick | output | 1 | One-cycle pulse at the bit rate |
| data_bits | output | 4 | Decoded data bit count |
| parity_en | output | 1 | Parity bit present |
| parity_odd | output | 1 | Odd parity when parity is present |
| stop_bits | output | 2 | Decoded stop bit count |
| frame_bits | output | 4 | Total bits per character |
| timeout | output | 1 | One-cycle receive timeout pulse |

## Verification
A corrupted divider count shows up on the port as a wrong spacing between `baud_tick` pulses. The bench sees this within one tick period after the first two ticks, so it measures the third interval. A fault in the timeout counter or its armed flag shows up as a `timeout` pulse on the wrong tick, as a missing pulse, or as a repeated pulse. The bench catches this within 4*`frame_bits` ticks of the last `rx_char` and watches a further window afterwards for a stray pulse. Decode faults are visible in the same cycle the mode changes.

// File: rtl/uart_char_timer.sv
module uart_char_timer #(
  parameter int DIV_W  = 16,
  parameter int BDIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        mode,
  input  logic              div_wr,
  input  logic [DIV_W-1:0]  div_in,
  input  logic [BDIV_W-1:0] bit_div,
  input  logic              rx_char,
  output logic              baud_tick,
  output logic [3:0]        data_bits,
  output logic              parity_en,
  output logic              parity_odd,
  output logic [1:0]        stop_bits,
  output logic [3:0]        frame_bits,
  output logic              timeout
);
  localparam logic [DIV_W-1:0] DIV_RESET = DIV_W'(15);
  localparam int TO_W = 6;

  logic [DIV_W-1:0]  div_q;
  logic [2:0]        pre_cnt;
  logic [DIV_W-1:0]  samp_cnt;
  logic [BDIV_W-1:0] bit_cnt;
  logic [TO_W-1:0]   to_cnt;
  logic              armed;
  logic              pre_en, samp_hit, bit_hit;
  logic [TO_W-1:0]   to_limit;

  assign data_bits  = (mode[2:1] == 2'd3) ? 4'd6 :
                      (mode[2:1] == 2'd2) ? 4'd7 : 4'd8;
  assign parity_en  = (mode[5:3] == 3'd0) || (mode[5:3] == 3'd1);
  assign parity_odd = (mode[5:3] == 3'd1);
  assign stop_bits  = (mode[7:6] == 2'd3) ? 2'd1 : 2'd2;
  assign frame_bits = 4'd1 + data_bits + {3'd0, parity_en} + {2'd0, stop_bits};
  assign to_limit   = {frame_bits, 2'b00};

  assign pre_en   = !mode[0] || (pre_cnt == 3'd7);
  assign samp_hit = pre_en && (div_q != '0) && (samp_cnt >= div_q - DIV_W'(1));
  assign bit_hit  = samp_hit && (bit_cnt >= bit_div);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      div_q <= DIV_RESET;
    else if (div_wr) div_q <= div_in;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       pre_cnt <= '0;
    else if (mode[0]) pre_cnt <= pre_cnt + 3'd1;
    else              pre_cnt <= '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              samp_cnt <= '0;
    else if (div_q == '0)    samp_cnt <= '0;
    else if (pre_en)         samp_cnt <= samp_hit ? '0 : samp_cnt + DIV_W'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        bit_cnt <= '0;
    else if (samp_hit) bit_cnt <= bit_hit ? '0 : bit_cnt + BDIV_W'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) baud_tick <= 1'b0;
    else        baud_tick <= bit_hit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      armed   <= 1'b0;
      to_cnt  <= '0;
      timeout <= 1'b0;
    end else begin
      timeout <= 1'b0;
      if (rx_char) begin
        armed  <= 1'b1;
        to_cnt <= '0;
      end else if (armed && baud_tick) begin
        if (to_cnt >= to_limit - TO_W'(1)) begin
          timeout <= 1'b1;
          armed   <= 1'b0;
          to_cnt  <= '0;
        end else begin
          to_cnt <= to_cnt + TO_W'(1);
        end
      end
    end
endmodule

// File: rtl/uart_char_timer_chk.sv
module uart_char_timer_chk #(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DIV_W-1:0] div_q,
  input logic             baud_tick,
  input logic             rx_char,
  input logic             timeout,
  input logic [3:0]       data_bits
);
  AST_ZERO_DIV_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q == '0) |=> !baud_tick); // R4
  AST_TIMEOUT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> !timeout); // R9
  AST_TIMEOUT_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> $past(baud_tick)); // R9
  AST_RX_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_char |=> !timeout); // R10
  AST_DATA_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (data_bits >= 4'd6) && (data_bits <= 4'd8)); // R5
endmodule

bind uart_char_timer uart_char_timer_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .div_q(div_q), .baud_tick(baud_tick),
  .rx_char(rx_char), .timeout(timeout), .data_bits(data_bits));

// File: tb/tb_uart_char_timer.sv
module tb_uart_char_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] mode = 8'h00;
  logic div_wr = 1'b0;
  logic [15:0] div_in = 16'd0;
  logic [7:0] bit_div = 8'd0;
  logic rx_char = 1'b0;
  logic baud_tick, parity_en, parity_odd, timeout;
  logic [3:0] data_bits, frame_bits;
  logic [1:0] stop_bits;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  uart_char_timer dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .div_wr(div_wr), .div_in(div_in),
    .bit_div(bit_div), .rx_char(rx_char), .baud_tick(baud_tick),
    .data_bits(data_bits), .parity_en(parity_en), .parity_odd(parity_odd),
    .stop_bits(stop_bits), .frame_bits(frame_bits), .timeout(timeout));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic load_div(input int d);
    @(negedge clk);
    div_in = 16'(d);
    div_wr = 1'b1;
    @(negedge clk);
    div_wr = 1'b0;
  endtask

  task automatic wait_tick(output bit seen);
    seen = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (baud_tick) begin seen = 1; break; end
    end
  endtask

  task automatic measure_period(input int exp, input string tag);
    bit seen;
    int n;
    wait_tick(seen);
    wait_tick(seen);
    n = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      n++;
      if (baud_tick) break;
    end
    check(n == exp, tag, n, exp);
  endtask

  task automatic test_reset;
    check(baud_tick == 1'b0, "R1 tick low in reset", baud_tick, 0);
    check(timeout == 1'b0, "R1 timeout low in reset", timeout, 0);
    @(negedge clk);
    rst_n = 1'b1;
    measure_period(15, "R1 default divisor 15");
  endtask

  task automatic test_periods;
    mode = 8'h00;
    load_div(3); bit_div = 8'd0;
    measure_period(3, "R2 D=3 B=0");
    load_div(4); bit_div = 8'd2;
    measure_period(12, "R2 D=4 B=2");
    load_div(1); bit_div = 8'd0;
    measure_period(1, "R2 D=1 B=0");
    mode = 8'h01;
    load_div(4); bit_div = 8'd2;
    measure_period(96, "R3 prescale D=4 B=2");
    load_div(1); bit_div = 8'd1;
    measure_period(16, "R3 prescale D=1 B=1");
    mode = 8'h00;
  endtask

  task automatic test_zero_div;
    int n = 0;
    load_div(0);
    bit_div = 8'd0;
    @(negedge clk);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (baud_tick) n++;
    end
    check(n == 0, "R4 zero divisor no ticks", n, 0);
  endtask

  task automatic test_decode(input logic [7:0] m, input int db, input int pe,
                             input int po, input int sb);
    @(negedge clk);
    mode = m;
    #1;
    check(data_bits == 4'(db), "R5 data bits", data_bits, db);
    check(parity_en == pe[0] && parity_odd == po[0], "R6 parity",
          {parity_en, parity_odd}, {pe[0], po[0]});
    check(stop_bits == 2'(sb), "R7 stop bits", stop_bits, sb);
    check(frame_bits == 4'(1 + db + pe + sb), "R8 frame bits", frame_bits, 1 + db + pe + sb);
  endtask

  task automatic pulse_rx;
    @(negedge clk);
    rx_char = 1'b1;
    @(negedge clk);
    rx_char = 1'b0;
  endtask

  task automatic count_to_timeout(output int n, output bit fired);
    n = 0;
    fired = 0;
    if (timeout) begin fired = 1; return; end
    if (baud_tick) n++;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (timeout) begin fired = 1; break; end
      if (baud_tick) n++;
    end
  endtask

  task automatic test_timeout(input logic [7:0] m, input int frame);
    int n;
    bit fired;
    mode = m;
    load_div(2); bit_div = 8'd0;
    pulse_rx();
    count_to_timeout(n, fired);
    check(fired, "R9 timeout fired", fired, 1);
    check(n == 4 * frame, "R9 ticks before timeout", n, 4 * frame);
    @(negedge clk);
    check(timeout == 1'b0, "R9 single cycle pulse", timeout, 0);
  endtask

  task automatic test_restart;
    int n, k;
    bit fired;
    mode = 8'hE0;
    load_div(2); bit_div = 8'd0;
    pulse_rx();
    k = 0;
    fired = 0;
    for (int i = 0; i < 1000 && k < 20; i++) begin
      @(negedge clk);
      if (timeout) fired = 1;
      if (baud_tick) k++;
    end
    check(!fired, "R10 no early timeout", fired, 0);
    pulse_rx();
    check(timeout == 1'b0, "R10 no timeout after rx", timeout, 0);
    count_to_timeout(n, fired);
    check(n == 40, "R10 count restarted", n, 40);
    n = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (timeout) n++;
    end
    check(n == 0, "R11 no repeat timeout", n, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    test_periods();
    test_zero_div();
    test_decode(8'hE0, 8, 0, 0, 1);
    test_decode(8'h04, 7, 1, 0, 2);
    test_decode(8'hCE, 6, 1, 1, 1);
    test_decode(8'h12, 8, 0, 0, 2);
    test_timeout(8'hE0, 10);
    test_timeout(8'h04, 11);
    test_timeout(8'hCE, 9);
    test_restart();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule